// File: doc/BRIEF.md
# Viral error containment unit

This unit sits on an outgoing packet link. Several error sources report uncorrectable errors to it. As soon as any of them asserts, the unit latches a sticky "viral" condition. From that point on, every packet that starts on the link leaves with a viral flag raised. Any packet whose destination class is the I/O class is not forwarded at all: it is swallowed at the input. The input keeps accepting traffic so that upstream logic never stalls behind a blocked packet.

Decisions are made per packet, on its first beat. A packet that is already part-way through the unit when an error lands finishes exactly as it began, and the new treatment starts at the next packet. Software sees the condition through a status word. That word holds the viral bit, the index of the source that caused entry and a saturating count of discarded packets. A single-cycle interrupt marks the entry. Software leaves the viral state with a clear write. A reset also leaves it.

Top module: `fault_quarantine`

## Requirements
- R1: When any bit of `err_i` is high at a clock edge, status bit 0 (viral) is high from that edge on.
- R2: While viral, every packet whose first beat is accepted is forwarded with `out_viral` high on all of its beats, unless R3 drops it.
- R3: While viral, a packet whose first beat has `in_dest` equal to `IO_DEST` (default 3) is dropped. None of its beats appears at the output, and `in_ready` stays high for those beats whatever the level of `out_ready`.
- R4: Beats after the first keep the forward, drop and mark decisions taken on the first beat, even if the viral state changes mid-packet.
- R5: A cycle with `ctl_we` and `ctl_clear` both high and no error bit set leaves the viral state at that edge and zeroes the source and count fields. A write with `ctl_clear` low has no effect.
- R6: A clear write in a cycle where any error bit is high is ignored, so the unit is viral after that edge.
- R7: Status bits [SRC_W:1] (bits 2:1 by default) hold the lowest-numbered error bit that was high on the entry edge. Errors seen while already viral leave the field unchanged.
- R8: Status bits [SRC_W+CNT_W:SRC_W+1] (bits 10:3 by default) count dropped packets, one per packet, and saturate at all-ones.
- R9: `irq_o` is high for exactly one cycle, on the edge that enters the viral state, and never while the unit is already viral.
- R10: When not viral, every packet is forwarded unchanged with `out_viral` low, and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_i | input | NSRC | Uncorrectable error reports, one per source |
| ctl_we | input | 1 | Control register write strobe |
| ctl_clear | input | 1 | Write data bit that requests leaving the viral state |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input beat payload |
| in_dest | input | DEST_W | Destination class, sampled on the first beat |
| in_last | input | 1 | Final beat of the packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DW | Output payload |
| out_dest | output | DEST_W | Output destination class |
| out_last | output | 1 | Output final beat |
| out_viral | output | 1 | Viral flag on the output beat |
| status_o | output | 1+SRC_W+CNT_W | {drop count, first source, viral} |
| irq_o | output | 1 | Entry interrupt pulse |

## Verification
The bench walks all fifteen non-zero error patterns. A unit with a wrong priority encoder would report the wrong source, and one that re-arms its interrupt would pulse on a second error. Every destination class is sent with packet lengths of one to three beats, in both states. A unit that decided per beat would split a packet hit by an error mid-flight, and one that tied ready to downstream for dropped packets would stall its input. A clear write that coincides with an error is exercised, along with enough drops to reach counter saturation. A unit that let the clear win would leave the viral state, and one that wrapped the counter would read back a small number.

// File: rtl/fq_pkg.sv
// Package: shared types and helpers for the viral containment unit.
// Assumes error vectors of at most 32 sources.
package fq_pkg;

    // Per-packet treatment decided on the first beat.
    typedef struct packed {
        logic mark;
        logic drop;
    } pkt_treat_t;

    // Index of the lowest set bit; zero when none is set.
    function automatic int unsigned lowest_set(input logic [31:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/fq_state.sv
// Module: sticky viral state, first-source capture and entry interrupt.
// Assumes NSRC >= 2. An error always wins over a clear in the same cycle.
module fq_state #(
    parameter int NSRC  = 4,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  err_i,
    input  logic             ctl_we,
    input  logic             ctl_clear,
    output logic             viral_o,
    output logic [SRC_W-1:0] src_o,
    output logic             irq_o,
    output logic             clr_ok_o
);
    logic err_any;
    logic viral_q;
    logic irq_q;
    logic [SRC_W-1:0] src_q;

    // Combine error reports and qualify the clear request.
    always_comb begin
        err_any  = |err_i;
        clr_ok_o = ctl_we && ctl_clear && !err_any;
    end

    // Hold the viral bit, the entry source and the one-cycle interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viral_q <= 1'b0;
            src_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= err_any && !viral_q;
            if (err_any) begin
                viral_q <= 1'b1;
                if (!viral_q) src_q <= SRC_W'(fq_pkg::lowest_set(32'(err_i)));
            end else if (clr_ok_o) begin
                viral_q <= 1'b0;
                src_q   <= '0;
            end
        end
    end

    assign viral_o = viral_q;
    assign src_o   = src_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/fq_gate.sv
// Module: packet-boundary tracker that marks or drops whole packets.
// Assumes a valid/ready stream whose packets end on in_last; the treatment
// is fixed on the first beat and reused for the rest of the packet.
module fq_gate #(
    parameter int                DEST_W  = 2,
    parameter logic [DEST_W-1:0] IO_DEST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viral_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DEST_W-1:0] in_dest,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_viral,
    output logic              drop_pkt_o
);
    import fq_pkg::*;

    logic       mid_q;
    pkt_treat_t held_q;
    pkt_treat_t now_t;
    logic       accept;

    // Pick the treatment: fresh on a first beat, held otherwise.
    always_comb begin
        if (!mid_q) begin
            now_t.mark = viral_i;
            now_t.drop = viral_i && (in_dest == IO_DEST);
        end else begin
            now_t = held_q;
        end
        out_valid  = in_valid && !now_t.drop;
        in_ready   = now_t.drop ? 1'b1 : out_ready;
        out_viral  = out_valid && now_t.mark;
        accept     = in_valid && in_ready;
        drop_pkt_o = accept && !mid_q && now_t.drop;
    end

    // Track packet boundaries and latch the first-beat treatment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            held_q <= '0;
        end else if (accept) begin
            mid_q <= !in_last;
            if (!mid_q) held_q <= now_t;
        end
    end
endmodule

// File: rtl/fq_dropcnt.sv
// Module: saturating counter of dropped packets, zeroed on clear.
// Assumes at most one drop event per cycle.
module fq_dropcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             zero_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count drops, stop at all-ones, zero on an accepted clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (zero_i)                  cnt_q <= '0;
        else if (inc_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/fault_quarantine.sv
// Module: top of the viral containment unit. Joins the state holder,
// the packet gate and the drop counter; payload passes straight through.
// Assumes the link is combinational from input to output (no buffering).
module fault_quarantine #(
    parameter int                NSRC    = 4,
    parameter int                DW      = 8,
    parameter int                DEST_W  = 2,
    parameter logic [DEST_W-1:0] IO_DEST = '1,
    parameter int                CNT_W   = 8,
    localparam int               SRC_W   = $clog2(NSRC),
    localparam int               STAT_W  = 1 + SRC_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   err_i,
    input  logic              ctl_we,
    input  logic              ctl_clear,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_data,
    input  logic [DEST_W-1:0] in_dest,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic [DEST_W-1:0] out_dest,
    output logic              out_last,
    output logic              out_viral,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic             viral;
    logic [SRC_W-1:0] src;
    logic             clr_ok;
    logic             drop_pkt;
    logic [CNT_W-1:0] cnt;

    fq_state #(.NSRC(NSRC)) u_state (
        .clk(clk), .rst_n(rst_n), .err_i(err_i),
        .ctl_we(ctl_we), .ctl_clear(ctl_clear),
        .viral_o(viral), .src_o(src), .irq_o(irq_o), .clr_ok_o(clr_ok)
    );

    fq_gate #(.DEST_W(DEST_W), .IO_DEST(IO_DEST)) u_gate (
        .clk(clk), .rst_n(rst_n), .viral_i(viral),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_viral(out_viral), .drop_pkt_o(drop_pkt)
    );

    fq_dropcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(drop_pkt),
        .zero_i(clr_ok), .cnt_o(cnt)
    );

    // Pass payload fields through and assemble the status word.
    always_comb begin
        out_data = in_data;
        out_dest = in_dest;
        out_last = in_last;
        status_o = {cnt, src, viral};
    end
endmodule

// File: rtl/fq_checker.sv
// Module: port-level properties of the viral containment unit.
// Assumes the default field layout of status_o: {count, source, viral}.
module fq_checker #(
    parameter int                NSRC    = 4,
    parameter int                DEST_W  = 2,
    parameter logic [DEST_W-1:0] IO_DEST = '1,
    parameter int                STAT_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   err_i,
    input logic              ctl_we,
    input logic              ctl_clear,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DEST_W-1:0] in_dest,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_viral,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o
);
    logic mid_c;

    // Independent packet-boundary tracker seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mid_c <= 1'b0;
        else if (in_valid && in_ready) mid_c <= !in_last;
    end

    // R1
    viral_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_i) |=> status_o[0]);
    // R5
    viral_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !(ctl_we && ctl_clear)) |=> status_o[0]);
    // R6
    clear_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_clear && (|err_i)) |=> status_o[0]);
    // R2
    first_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mid_c && status_o[0]) |-> out_viral);
    // R3
    io_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mid_c && status_o[0] && in_dest == IO_DEST) |-> (in_ready && !out_valid));
    // R9
    irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R9
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[0] && !$past(status_o[0])));
    // R10
    calm_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mid_c && !status_o[0]) |-> !out_viral);
endmodule

bind fault_quarantine fq_checker #(
    .NSRC(NSRC), .DEST_W(DEST_W), .IO_DEST(IO_DEST), .STAT_W(STAT_W)
) u_fq_chk (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .ctl_we(ctl_we),
    .ctl_clear(ctl_clear), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_last(in_last), .out_valid(out_valid),
    .out_viral(out_viral), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/fault_quarantine_bench.sv
// Bench: sweeps error patterns, destinations and packet lengths.
module fault_quarantine_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] err_i;
    logic       ctl_we, ctl_clear;
    logic       in_valid, in_ready, in_last;
    logic [7:0] in_data, out_data;
    logic [1:0] in_dest, out_dest;
    logic       out_valid, out_ready, out_last, out_viral;
    logic [10:0] status_o;
    logic       irq_o;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    fault_quarantine u_fault_quarantine (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .ctl_we(ctl_we),
        .ctl_clear(ctl_clear), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_dest(in_dest), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_dest(out_dest), .out_last(out_last), .out_viral(out_viral),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_eq(input int act, input int exp, input string what);
        chk(act == exp, what, act, exp);
    endtask

    // One beat: drive at negedge, check the combinational outputs, take the edge.
    task automatic beat(input [1:0] d, input bit last, input [7:0] data,
                        input bit fwd, input bit mark, input [3:0] e, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_dest = d; in_last = last; in_data = data;
        out_ready = 1'b1; err_i = e;
        #1;
        chk_eq(out_valid, fwd, {req, " out_valid"});
        if (fwd) begin
            chk_eq(out_data, data, {req, " out_data"});
            chk_eq(out_viral, mark, {req, " out_viral"});
        end
        chk_eq(in_ready, 1, {req, " in_ready"});
        @(posedge clk);
        #1;
        in_valid = 1'b0; err_i = '0;
    endtask

    task automatic packet(input [1:0] d, input int len, input bit fwd, input bit mark, input string req);
        for (int b = 0; b < len; b++)
            beat(d, b == len - 1, 8'(d * 16 + b), fwd, mark, 4'd0, req);
    endtask

    task automatic err_pulse(input [3:0] e);
        @(negedge clk); err_i = e;
        @(posedge clk); #1;
        err_i = '0;
    endtask

    task automatic clr(input bit bitval, input [3:0] e);
        @(negedge clk); ctl_we = 1'b1; ctl_clear = bitval; err_i = e;
        @(posedge clk); #1;
        ctl_we = 1'b0; ctl_clear = 1'b0; err_i = '0;
    endtask

    function automatic int low_bit(input int p);
        for (int i = 0; i < 4; i++) if (p[i]) return i;
        return 0;
    endfunction

    initial begin
        rst_n = 1'b0; err_i = '0; ctl_we = 0; ctl_clear = 0;
        in_valid = 0; in_data = '0; in_dest = '0; in_last = 0; out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk_eq(status_o, 0, "reset status");
        chk_eq(irq_o, 0, "reset irq");

        // R1 R7 R9: every non-zero error pattern, then a second error while viral.
        for (int p = 1; p < 16; p++) begin
            err_pulse(4'(p));
            chk_eq(status_o[0], 1, "R1 viral after error");
            chk_eq(irq_o, 1, "R9 irq on entry");
            chk_eq(status_o[2:1], low_bit(p), "R7 first source");
            @(posedge clk); #1;
            chk_eq(irq_o, 0, "R9 irq one cycle");
            err_pulse(4'(~p));
            chk_eq(irq_o, 0, "R9 no irq while viral");
            chk_eq(status_o[2:1], low_bit(p), "R7 source held");
            clr(1'b1, 4'd0);
            chk_eq(status_o, 0, "R5 clear zeroes status");
        end

        // R10: normal forwarding, every class and length.
        for (int d = 0; d < 4; d++)
            for (int len = 1; len <= 3; len++)
                packet(2'(d), len, 1'b1, 1'b0, "R10 pass");
        @(negedge clk); in_valid = 1; in_dest = 2'd3; in_last = 1; out_ready = 0; #1;
        chk_eq(in_ready, 0, "R10 ready follows downstream");
        @(negedge clk); in_valid = 0; out_ready = 1;

        // R2 R3: viral forwarding and blocking.
        err_pulse(4'b0100);
        for (int d = 0; d < 4; d++)
            for (int len = 1; len <= 3; len++)
                packet(2'(d), len, d != 3, 1'b1, (d == 3) ? "R3 drop" : "R2 mark");
        @(negedge clk); #1;
        chk_eq(status_o[10:3], 3, "R8 drop count");
        @(negedge clk); in_valid = 1; in_dest = 2'd3; in_last = 1; out_ready = 0; #1;
        chk_eq(in_ready, 1, "R3 no stall on blocked packet");
        chk_eq(out_valid, 0, "R3 blocked not forwarded");
        @(negedge clk); in_valid = 0; out_ready = 1;
        chk_eq(status_o[10:3], 4, "R8 count after stalled-output drop");

        // R5: write without the clear bit is ignored; R6: clear with error ignored.
        clr(1'b0, 4'd0);
        chk_eq(status_o[0], 1, "R5 write without clear bit");
        clr(1'b1, 4'b0010);
        chk_eq(status_o[0], 1, "R6 clear lost to error");
        chk_eq(status_o[2:1], 2, "R7 source after ignored clear");
        chk_eq(irq_o, 0, "R9 no irq on ignored clear");
        clr(1'b1, 4'd0);
        chk_eq(status_o, 0, "R5 clear");
        clr(1'b1, 4'b1000);
        chk_eq(status_o[0], 1, "R6 entry despite clear");
        chk_eq(irq_o, 1, "R9 irq on entry with clear");
        clr(1'b1, 4'd0);

        // R4: error arrives mid-packet, packet to I/O class finishes untouched.
        beat(2'd3, 1'b0, 8'hA0, 1'b1, 1'b0, 4'd0, "R4 first beat");
        beat(2'd3, 1'b0, 8'hA1, 1'b1, 1'b0, 4'b0001, "R4 beat with error");
        beat(2'd3, 1'b1, 8'hA2, 1'b1, 1'b0, 4'd0, "R4 last beat unchanged");
        packet(2'd3, 2, 1'b0, 1'b1, "R4 next packet dropped");
        // R4: clear mid-packet, marked packet stays marked.
        beat(2'd1, 1'b0, 8'hB0, 1'b1, 1'b1, 4'd0, "R4 marked first");
        clr(1'b1, 4'd0);
        beat(2'd1, 1'b1, 8'hB1, 1'b1, 1'b1, 4'd0, "R4 marked after clear");
        packet(2'd1, 1, 1'b1, 1'b0, "R10 after clear");

        // R8: saturation.
        err_pulse(4'b0001);
        for (int k = 0; k < 260; k++) packet(2'd3, 1, 1'b0, 1'b1, "R8 drop");
        chk_eq(status_o[10:3], 255, "R8 saturates");
        clr(1'b1, 4'd0);
        chk_eq(status_o[10:3], 0, "R5 count zeroed");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule